// File: doc/BRIEF.md
# Paged Logical-to-Physical Memory Mapper

This block sits between a CPU with a 16-bit address bus and a 2 MiB physical memory space. The logical space is split into eight execution pages of 8 KiB each. The three most significant address bits pick one of eight 8-bit page registers. That register's contents become the upper byte of a 21-bit physical address, and the remaining 13 bits pass through unchanged as the offset.

The physical page number also picks a memory region. Each region has its own chip select and its own number of wait states:
- slow DRAM, pages 00 to 3F;
- fast SRAM, pages E8 to EF;
- boot ROM, pages F0 to FF.

The ROM is only partly decoded, so every ROM page folds onto one of two pages. Pages outside the three regions are unpopulated: they select nothing, and a read from them returns all ones. Two logical windows belong to RAM inside the CPU. In those windows the mapper drives no external strobe, whatever the last page register holds.

System software loads the page registers through a small indexed write port and can read them back through the same index. A wait request holds the CPU for the extra cycles that the selected region needs.

Top module: `page_mapper`

## Requirements
- R1: `phys_addr` equals the page register chosen by `cpu_addr[15:13]`, followed by `cpu_addr[12:0]`. Example: with register 5 holding 2C, logical A080 gives 058080.
- R2: When `reg_we` is high at a clock edge, `reg_wdata` is stored in register `reg_idx`. `reg_rdata` shows register `reg_idx` combinationally, so the new value is visible in the cycle after the write.
- R3: Reset loads 8'hF0 into the even-numbered page registers and 8'hF1 into the odd-numbered ones.
- R4: A request to physical pages 00–3F asserts `cs_dram` and needs 1 wait state.
- R5: A request to physical pages E8–EF asserts `cs_sram` and needs 0 wait states.
- R6: A read of pages F0–FF asserts `cs_rom` and needs 2 wait states. Only page bit 0 is decoded: `phys_addr[20:13]` reads F0 or F1.
- R7: A write to pages F0–FF drives no chip select, drives `mem_we` low and needs no wait state.
- R8: Pages 40–E7 drive no chip select and no wait. Whenever the address points there, `cpu_rdata` is 8'hFF.
- R9: For logical F000–F0FB and FFFC–FFFF, `onchip_hit` is 1 and no chip select, `mem_we` or wait is driven. F0FC–FFFB are mapped as usual.
- R10: While a request is held, `cpu_wait` is high for exactly the region's wait count, starting in the first cycle. It then drops for one cycle, which completes the access. A request held after that cycle starts a new access.
- R11: Chip selects and `mem_we` are driven only while `cpu_req` is high, at most one chip select at a time. `mem_we` is high exactly for DRAM or SRAM writes. Outside R8, `cpu_rdata` equals `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU logical address |
| cpu_req | input | 1 | Access request |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_wait | output | 1 | Hold request to the CPU |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| reg_we | input | 1 | Page register write enable |
| reg_idx | input | 3 | Page register index (write and readback) |
| reg_wdata | input | 8 | Page register write value |
| reg_rdata | output | 8 | Page register readback |
| phys_addr | output | 21 | Physical address |
| cs_dram | output | 1 | DRAM select |
| cs_sram | output | 1 | SRAM select |
| cs_rom | output | 1 | Boot ROM select |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Read data from memory |
| onchip_hit | output | 1 | Address lies in an on-chip RAM window |

## Verification
Accesses are tried against page registers holding values on both sides of every region boundary:
- 3F against 40, and E7 against E8, separate the region edges;
- F3 and F6 against F0 show the ROM fold;
- 2C checks plain concatenation.

Addresses step across each on-chip window edge (F0FB/F0FC, FFFB/FFFC) with a DRAM page behind them. A leak there would show up as a chip select.

Requests are held for several cycles in every region. This separates a correct wait count from one that is off by one, and shows whether the counter restarts after each completed access. Reads and writes alternate, which exposes the ROM write block and the write strobe.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_DRAM = 2'd1,
        RG_SRAM = 2'd2,
        RG_ROM  = 2'd3
    } region_t;

endpackage

// File: rtl/page_regfile.sv
module page_regfile #(
    parameter int NPG      = 8,
    parameter int PW       = 8,
    parameter logic [PW-1:0] BOOT_PG = 8'hF0,
    localparam int IW      = $clog2(NPG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [PW-1:0] wr_data,
    input  logic [IW-1:0] cpu_idx,
    output logic [PW-1:0] cpu_page,
    output logic [PW-1:0] rd_page
);

    typedef struct packed {
        logic [NPG-1:0][PW-1:0] pg;
    } regs_t;

    regs_t st_d, st_q;
    regs_t rst_val;

    generate
        for (genvar g = 0; g < NPG; g++) begin : g_rst
            assign rst_val.pg[g] = BOOT_PG | PW'(g % 2);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.pg[wr_idx] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= rst_val;
        else        st_q <= st_d;
    end

    assign cpu_page = st_q.pg[cpu_idx];
    assign rd_page  = st_q.pg[wr_idx];

    // R2: a written value is held in the addressed register one edge later
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.pg[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/region_decode.sv
module region_decode
    import mapper_pkg::*;
#(
    parameter int PW  = 8,
    parameter int LAW = 16,
    parameter logic [PW-1:0] DRAM_LAST  = 8'h3F,
    parameter logic [PW-1:0] SRAM_FIRST = 8'hE8,
    parameter logic [PW-1:0] SRAM_LAST  = 8'hEF,
    parameter logic [PW-1:0] ROM_FIRST  = 8'hF0,
    parameter logic [LAW-1:0] WIN0_LO = 16'hF000,
    parameter logic [LAW-1:0] WIN0_HI = 16'hF0FB,
    parameter logic [LAW-1:0] WIN1_LO = 16'hFFFC
) (
    input  logic [PW-1:0]  page,
    input  logic [LAW-1:0] laddr,
    output region_t        region,
    output logic           onchip
);

    always_comb begin
        if (page <= DRAM_LAST)                            region = RG_DRAM;
        else if (page >= SRAM_FIRST && page <= SRAM_LAST) region = RG_SRAM;
        else if (page >= ROM_FIRST)                       region = RG_ROM;
        else                                              region = RG_NONE;
    end

    assign onchip = (laddr >= WIN0_LO && laddr <= WIN0_HI) || (laddr >= WIN1_LO);

endmodule

// File: rtl/wait_gen.sv
module wait_gen #(
    parameter int WS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [WS_W-1:0] need,
    output logic            wait_o
);

    typedef struct packed {
        logic [WS_W-1:0] cnt;
    } wst_t;

    wst_t st_d, st_q;

    assign wait_o = req && (need > st_q.cnt);

    always_comb begin
        st_d = st_q;
        if (req && wait_o) st_d.cnt = st_q.cnt + 1'b1;
        else               st_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: after the last wait cycle of a held request the wait drops
    p_wait_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wait_o && (st_q.cnt == need - 1'b1)) ##1 (req && $stable(need)) |-> !wait_o);

    // R10: a request never sees more waits than its region needs
    p_wait_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req && $stable(need) && $past(req) |-> st_q.cnt <= need);

endmodule

// File: rtl/page_mapper.sv
module page_mapper
    import mapper_pkg::*;
#(
    parameter int LAW   = 16,
    parameter int OFF_W = 13,
    parameter int PW    = 8,
    parameter int DW    = 8,
    parameter int WS_W  = 2,
    parameter logic [WS_W-1:0] DRAM_WS = 2'd1,
    parameter logic [WS_W-1:0] SRAM_WS = 2'd0,
    parameter logic [WS_W-1:0] ROM_WS  = 2'd2,
    localparam int IW   = LAW - OFF_W,
    localparam int NPG  = 1 << IW,
    localparam int PAW  = PW + OFF_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [LAW-1:0] cpu_addr,
    input  logic           cpu_req,
    input  logic           cpu_wr,
    output logic           cpu_wait,
    output logic [DW-1:0]  cpu_rdata,
    input  logic           reg_we,
    input  logic [IW-1:0]  reg_idx,
    input  logic [PW-1:0]  reg_wdata,
    output logic [PW-1:0]  reg_rdata,
    output logic [PAW-1:0] phys_addr,
    output logic           cs_dram,
    output logic           cs_sram,
    output logic           cs_rom,
    output logic           mem_we,
    input  logic [DW-1:0]  mem_rdata,
    output logic           onchip_hit
);

    localparam logic [PW-1:0] ROM_BASE = 8'hF0;

    logic [PW-1:0]   cur_page;
    logic [PW-1:0]   out_page;
    region_t         region;
    logic            onchip;
    logic            ext;
    logic [WS_W-1:0] need;

    page_regfile #(.NPG(NPG), .PW(PW), .BOOT_PG(ROM_BASE)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we),
        .wr_idx   (reg_idx),
        .wr_data  (reg_wdata),
        .cpu_idx  (cpu_addr[LAW-1:OFF_W]),
        .cpu_page (cur_page),
        .rd_page  (reg_rdata)
    );

    region_decode #(.PW(PW), .LAW(LAW)) u_dec (
        .page   (cur_page),
        .laddr  (cpu_addr),
        .region (region),
        .onchip (onchip)
    );

    assign ext = cpu_req && !onchip;

    always_comb begin
        out_page = cur_page;
        if (region == RG_ROM) out_page = ROM_BASE | {{(PW-1){1'b0}}, cur_page[0]};
    end

    always_comb begin
        need = '0;
        if (!onchip) begin
            case (region)
                RG_DRAM: need = DRAM_WS;
                RG_SRAM: need = SRAM_WS;
                RG_ROM:  need = cpu_wr ? '0 : ROM_WS;
                default: need = '0;
            endcase
        end
    end

    wait_gen #(.WS_W(WS_W)) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (cpu_req),
        .need   (need),
        .wait_o (cpu_wait)
    );

    assign phys_addr  = {out_page, cpu_addr[OFF_W-1:0]};
    assign cs_dram    = ext && (region == RG_DRAM);
    assign cs_sram    = ext && (region == RG_SRAM);
    assign cs_rom     = ext && (region == RG_ROM) && !cpu_wr;
    assign mem_we     = ext && cpu_wr && (region == RG_DRAM || region == RG_SRAM);
    assign onchip_hit = onchip;
    assign cpu_rdata  = (!onchip && region == RG_NONE) ? {DW{1'b1}} : mem_rdata;

    // R9: on-chip windows never reach external memory
    p_onchip_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        onchip_hit |-> !(cs_dram || cs_sram || cs_rom || mem_we || cpu_wait));

    // R7: the ROM is never selected for a write
    p_rom_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rom |-> !cpu_wr && !mem_we);

    // R11: at most one chip select, and only with a request
    p_cs_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_dram, cs_sram, cs_rom}));
    p_cs_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |-> !(cs_dram || cs_sram || cs_rom || mem_we || cpu_wait));

    // R6: a ROM select always shows a folded page
    p_rom_fold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rom |-> phys_addr[PAW-1:OFF_W+1] == ROM_BASE[PW-1:1]);

endmodule

// File: tb/sim_page_mapper.sv
module sim_page_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_req = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        cpu_wait;
    logic [7:0]  cpu_rdata;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [20:0] phys_addr;
    logic        cs_dram, cs_sram, cs_rom, mem_we, onchip_hit;
    logic [7:0]  mem_rdata = 8'h5A;

    always #2.5 clk = ~clk;

    page_mapper u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_req(cpu_req),
        .cpu_wr(cpu_wr), .cpu_wait(cpu_wait), .cpu_rdata(cpu_rdata),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .phys_addr(phys_addr), .cs_dram(cs_dram),
        .cs_sram(cs_sram), .cs_rom(cs_rom), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .onchip_hit(onchip_hit)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_pg [8];
    int m_wc = 0;

    function automatic bit m_onchip(input logic [15:0] a);
        return (a >= 16'hF000 && a <= 16'hF0FB) || (a >= 16'hFFFC);
    endfunction

    // 0 none, 1 dram, 2 sram, 3 rom
    function automatic int m_region(input int p);
        if (p <= 'h3F) return 1;
        if (p >= 'hE8 && p <= 'hEF) return 2;
        if (p >= 'hF0) return 3;
        return 0;
    endfunction

    function automatic int m_need(input logic [15:0] a, input logic w);
        int r;
        r = m_region(m_pg[a[15:13]]);
        if (m_onchip(a)) return 0;
        if (r == 1) return 1;
        if (r == 3 && !w) return 2;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_pg[i] = (i % 2) ? 'hF1 : 'hF0;
            m_wc = 0;
        end else begin
            if (cpu_req && (m_need(cpu_addr, cpu_wr) > m_wc)) m_wc = m_wc + 1;
            else m_wc = 0;
            if (reg_we) m_pg[reg_idx] = reg_wdata;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int p, r;
            bit oc, ext, e_dram, e_sram, e_rom, e_we, e_wait;
            logic [20:0] e_pa;
            logic [7:0] e_rd;
            string tag;
            p = m_pg[cpu_addr[15:13]];
            r = m_region(p);
            oc = m_onchip(cpu_addr);
            ext = cpu_req && !oc;
            e_dram = ext && r == 1;
            e_sram = ext && r == 2;
            e_rom  = ext && r == 3 && !cpu_wr;
            e_we   = ext && cpu_wr && (r == 1 || r == 2);
            e_wait = cpu_req && (m_need(cpu_addr, cpu_wr) > m_wc);
            e_pa   = (r == 3) ? {7'h78, p[0], cpu_addr[12:0]} : {p[7:0], cpu_addr[12:0]};
            e_rd   = (!oc && r == 0) ? 8'hFF : mem_rdata;
            if (oc) tag = "R9";
            else if (r == 0) tag = "R8";
            else if (r == 3 && cpu_wr) tag = "R7";
            else if (r == 3) tag = "R6";
            else if (r == 2) tag = "R5";
            else tag = "R4";
            chk(phys_addr == e_pa, (r == 3) ? "R6" : "R1", "phys_addr", phys_addr, e_pa);
            chk({cs_dram, cs_sram, cs_rom} == {e_dram, e_sram, e_rom}, tag, "chip selects",
                {cs_dram, cs_sram, cs_rom}, {e_dram, e_sram, e_rom});
            chk(mem_we == e_we, "R11", "mem_we", mem_we, e_we);
            chk(cpu_wait == e_wait, "R10", "cpu_wait", cpu_wait, e_wait);
            chk(onchip_hit == oc, "R9", "onchip_hit", onchip_hit, oc);
            chk(cpu_rdata == e_rd, (r == 0 && !oc) ? "R8" : "R11", "cpu_rdata", cpu_rdata, e_rd);
            chk(reg_rdata == m_pg[reg_idx][7:0], "R2", "reg_rdata", reg_rdata, m_pg[reg_idx]);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input int idx, input int val);
        reg_we = 1'b1; reg_idx = 3'(idx); reg_wdata = 8'(val);
        step();
        reg_we = 1'b0;
        @(negedge clk);
        chk(reg_rdata == 8'(val), "R2", "readback after write", reg_rdata, val);
        #1;
    endtask

    task automatic access(input logic [15:0] a, input logic w, input int cycles);
        cpu_addr = a; cpu_wr = w; cpu_req = 1'b1;
        repeat (cycles) step();
        cpu_req = 1'b0;
        step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        // R3 reset contents
        for (int i = 0; i < 8; i++) begin
            reg_idx = 3'(i);
            #1;
            chk(reg_rdata == ((i % 2) ? 8'hF1 : 8'hF0), "R3", "reset page", reg_rdata,
                (i % 2) ? 8'hF1 : 8'hF0);
        end
        // reset vector fetch from ROM (R6)
        access(16'h0000, 1'b0, 4);
        wr_reg(5, 'h2C);
        wr_reg(0, 'h00);
        wr_reg(1, 'h3F);
        wr_reg(2, 'hE8);
        wr_reg(3, 'hEF);
        wr_reg(4, 'hF3);
        wr_reg(6, 'h40);
        wr_reg(7, 'h10);
        // R1 worked example
        cpu_addr = 16'hA080; cpu_req = 1'b1; cpu_wr = 1'b0;
        @(negedge clk);
        chk(phys_addr == 21'h058080, "R1", "example translation", phys_addr, 21'h058080);
        #1 cpu_req = 1'b0;
        step();
        begin
            logic [15:0] al [14] = '{16'h0000, 16'h3FFE, 16'h4000, 16'h7FFF, 16'h8000,
                                    16'hC010, 16'hF000, 16'hF0FB, 16'hF0FC, 16'hFFFB,
                                    16'hFFFC, 16'hFFFF, 16'hA080, 16'hE123};
            for (int k = 0; k < 14; k++) begin
                access(al[k], 1'b0, 4);
                access(al[k], 1'b1, 3);
            end
        end
        // unpopulated boundaries and ROM folding
        wr_reg(6, 'hE7);
        access(16'hC000, 1'b0, 2);
        wr_reg(4, 'hF6);
        access(16'h8004, 1'b0, 5);
        access(16'h8004, 1'b1, 2);
        wr_reg(4, 'hF1);
        access(16'h9FFF, 1'b0, 3);
        mem_rdata = 8'hA5;
        access(16'h2000, 1'b0, 2);
        access(16'h4001, 1'b1, 2);
        repeat (3) step();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule